// File: doc/BRIEF.md
# Wake Pattern Packet Detector

This block sits on the receive byte path of an Ethernet controller and scans each frame for the remote-wake pattern. The pattern is a run of synchronisation bytes, all ones, followed by a fixed number of back-to-back copies of the station address. The pattern may start at any byte of the frame, and any other bytes may come before or after it. The scan runs while the frame arrives. The wake decision is taken on the last byte of the frame, because only then are the frame check and destination-address results known. Both results arrive as inputs from neighbouring logic.

A qualified wake event sets a sticky power-management status bit. A link-up event also sets it. While the status bit is set and the bus-side wake enable is on, the active-low wake output is driven low, suited to an open-drain pad. A one-cycle request pulse goes to the bus message logic. Writing 1 to the status bit clears it and releases the wake output. The synchronisation length, the address length and the copy count are parameters.

Top module: `wkp_detect`

## Requirements
- R1: A frame that holds 6 bytes of 0xFF and then 16 back-to-back copies of the 6-byte station address sets `pme_status` in the cycle after its end-of-frame byte, when `rx_crc_ok`, `rx_da_ok`, `pat_wake_en` and `pme_gate_en` are all 1. The address is sent most significant byte first (`stn_addr[47:40]` first). Its first byte has bit 0 clear, as an individual address does.
- R2: The pattern is found at any byte offset, after any number of other bytes. It may end on the end-of-frame byte itself. Idle cycles (`rx_vld` = 0) inside a frame do not break a match.
- R3: A run of more than six 0xFF bytes still leads to a match. After a partial match fails, the search starts over. A failing byte of 0xFF counts toward a new synchronisation run.
- R4: No pattern wake is reported when `rx_crc_ok` or `rx_da_ok` is 0 on the end-of-frame byte.
- R5: A pattern wake needs both `pat_wake_en` and `pme_gate_en` set to 1.
- R6: A `link_up_evt` pulse sets `pme_status` when `pme_gate_en` is 1, and has no effect when `pme_gate_en` is 0.
- R7: `wake_n` is low exactly while `pme_status` and `bus_pme_en` are both 1. `wake_req` is a one-cycle pulse in the cycle after an accepted event, and only when `bus_pme_en` is 1.
- R8: A `pme_status_w1c` pulse clears `pme_status` in the next cycle. If a new event arrives in the same cycle, the event wins.
- R9: A found pattern is dropped at the next start-of-frame. Any one corrupted pattern byte prevents a wake, and so does a pattern with only 15 address copies.
- R10: After reset, `pme_status` = 0, `wake_n` = 1 and `wake_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_crc_ok | input | 1 | Frame check passed; sampled with the last byte |
| rx_da_ok | input | 1 | Destination address accepted; sampled with the last byte |
| stn_addr | input | 48 | Station address |
| pat_wake_en | input | 1 | Enables wake on pattern |
| pme_gate_en | input | 1 | Global enable for wake events |
| bus_pme_en | input | 1 | Bus-side enable for the wake output |
| link_up_evt | input | 1 | Link-up event pulse |
| pme_status_w1c | input | 1 | Write-1-to-clear strobe for the status bit |
| pme_status | output | 1 | Sticky wake status |
| wake_n | output | 1 | Active-low wake output |
| wake_req | output | 1 | One-cycle wake request pulse |

## Verification
The clean pattern is swept over starting offsets 0 to 10. Trailer lengths vary and some frames carry idle gaps, which separates offset handling from end-of-frame timing. Every one of the 102 pattern bytes is corrupted in turn, and a 15-copy pattern is sent, to show that only a complete, in-order pattern is accepted. Long 0xFF runs and failing bytes that are themselves 0xFF test the restart logic. Paired frames whose synchronisation run is one byte too short confirm that a match needs six 0xFF bytes. The qualifier inputs, the enable combinations, link-up, clearing and a pattern left in an earlier frame then show the gating and the output behaviour.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
   localparam int unsigned BYTE_W = 8;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/wkp_sync_run.sv
module wkp_sync_run
   import wkp_pkg::*;
#(
   parameter int unsigned SYNC_LEN = 6,
   parameter int unsigned DW       = BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_vld,
   input  logic          byte_sof,
   input  logic [DW-1:0] byte_in,
   output logic          armed
);
   localparam int unsigned RW = cnt_w(SYNC_LEN + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(SYNC_LEN);

   logic [RW-1:0] run_q, run_d, run_base;
   logic          is_ones;

   generate
      if (SYNC_LEN < 1) begin : g_bad_sync
         $error("wkp_sync_run: SYNC_LEN must be at least 1");
      end
   endgenerate

   assign is_ones  = (byte_in == {DW{1'b1}});
   assign run_base = byte_sof ? '0 : run_q;
   assign armed    = byte_vld && !byte_sof && (run_q == RUN_MAX);

   always_comb begin
      run_d = run_q;
      if (byte_vld) begin
         if (!is_ones)                run_d = '0;
         else if (run_base != RUN_MAX) run_d = run_base + RW'(1);
         else                          run_d = RUN_MAX;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_d;
   end

   a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX);
endmodule

// File: rtl/wkp_seq_match.sv
module wkp_seq_match
   import wkp_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned REPEATS    = 16,
   parameter int unsigned DW         = BYTE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     byte_vld,
   input  logic                     byte_sof,
   input  logic [DW-1:0]            byte_in,
   input  logic [ADDR_BYTES*DW-1:0] stn_addr,
   input  logic                     armed,
   output logic                     found_now
);
   localparam int unsigned SW = cnt_w(ADDR_BYTES);
   localparam int unsigned CW = cnt_w(REPEATS);
   localparam logic [SW-1:0] SEL_LAST  = SW'(ADDR_BYTES - 1);
   localparam logic [CW-1:0] COPY_LAST = CW'(REPEATS - 1);

   logic [DW-1:0] addr_b [ADDR_BYTES];
   logic [SW-1:0] sel_q, sel_d;
   logic [CW-1:0] copy_q, copy_d;
   logic          busy_q, busy_d, found_q, found_d;
   logic          busy_eff, found_eff, hit;

   generate
      if (ADDR_BYTES < 2) begin : g_bad_addr
         $error("wkp_seq_match: ADDR_BYTES must be at least 2");
      end
      if (REPEATS < 1) begin : g_bad_rep
         $error("wkp_seq_match: REPEATS must be at least 1");
      end
      for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
         assign addr_b[g] = stn_addr[(ADDR_BYTES-1-g)*DW +: DW];
      end
   endgenerate

   assign busy_eff  = busy_q  && !byte_sof;
   assign found_eff = found_q && !byte_sof;

   always_comb begin
      sel_d   = sel_q;
      copy_d  = copy_q;
      busy_d  = busy_eff;
      found_d = found_eff;
      hit     = 1'b0;
      if (byte_vld) begin
         if (busy_eff && byte_in == addr_b[sel_q]) begin
            if (sel_q == SEL_LAST) begin
               sel_d = '0;
               if (copy_q == COPY_LAST) begin
                  hit     = 1'b1;
                  busy_d  = 1'b0;
                  copy_d  = '0;
                  found_d = 1'b1;
               end else begin
                  copy_d = copy_q + CW'(1);
               end
            end else begin
               sel_d = sel_q + SW'(1);
            end
         end else begin
            busy_d = 1'b0;
            sel_d  = '0;
            copy_d = '0;
            if (armed && byte_in == addr_b[0]) begin
               busy_d = 1'b1;
               sel_d  = SW'(1);
            end
         end
      end
   end

   assign found_now = found_eff || hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         copy_q  <= '0;
         busy_q  <= 1'b0;
         found_q <= 1'b0;
      end else begin
         sel_q   <= sel_d;
         copy_q  <= copy_d;
         busy_q  <= busy_d;
         found_q <= found_d;
      end
   end

   a_r9_sof_drops_match: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_sof) |=> !found_q);
   a_r1_match_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found_q) |-> $past(byte_vld && armed == 1'b0));
endmodule

// File: rtl/wkp_wake_ctl.sv
module wkp_wake_ctl #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic byte_vld,
   input  logic byte_eof,
   input  logic crc_ok,
   input  logic da_ok,
   input  logic found_now,
   input  logic pat_wake_en,
   input  logic pme_gate_en,
   input  logic bus_pme_en,
   input  logic link_up_evt,
   input  logic status_w1c,
   output logic pme_status,
   output logic wake_n,
   output logic wake_req
);
   logic frame_hit, set_evt, status_q, status_d, req_q;

   assign frame_hit = byte_vld && byte_eof && found_now && crc_ok && da_ok
                      && pat_wake_en && pme_gate_en;
   assign set_evt   = frame_hit || (link_up_evt && pme_gate_en);

   generate
      if (SET_WINS) begin : g_set_wins
         assign status_d = set_evt ? 1'b1 : (status_w1c ? 1'b0 : status_q);
      end else begin : g_clr_wins
         assign status_d = status_w1c ? 1'b0 : (set_evt ? 1'b1 : status_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         req_q    <= set_evt && bus_pme_en;
      end
   end

   assign pme_status = status_q;
   assign wake_req   = req_q;
   assign wake_n     = !(status_q && bus_pme_en);

   a_r5_status_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pme_status) |-> $past(link_up_evt || (byte_vld && byte_eof && found_now)));
   a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(status_w1c && !link_up_evt && !(byte_vld && byte_eof)) |-> !pme_status);
   a_r7_req_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (pme_status || $past(status_w1c)));
endmodule

// File: rtl/wkp_detect.sv
module wkp_detect
   import wkp_pkg::*;
#(
   parameter int unsigned SYNC_LEN   = 6,
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned REPEATS    = 16,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_vld,
   input  logic [BYTE_W-1:0]            rx_byte,
   input  logic                         rx_sof,
   input  logic                         rx_eof,
   input  logic                         rx_crc_ok,
   input  logic                         rx_da_ok,
   input  logic [ADDR_BYTES*BYTE_W-1:0] stn_addr,
   input  logic                         pat_wake_en,
   input  logic                         pme_gate_en,
   input  logic                         bus_pme_en,
   input  logic                         link_up_evt,
   input  logic                         pme_status_w1c,
   output logic                         pme_status,
   output logic                         wake_n,
   output logic                         wake_req
);
   logic armed, found_now;

   wkp_sync_run #(.SYNC_LEN(SYNC_LEN), .DW(BYTE_W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (rx_vld),
      .byte_sof (rx_sof),
      .byte_in  (rx_byte),
      .armed    (armed)
   );

   wkp_seq_match #(.ADDR_BYTES(ADDR_BYTES), .REPEATS(REPEATS), .DW(BYTE_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (rx_vld),
      .byte_sof  (rx_sof),
      .byte_in   (rx_byte),
      .stn_addr  (stn_addr),
      .armed     (armed),
      .found_now (found_now)
   );

   wkp_wake_ctl #(.SET_WINS(SET_WINS)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (rx_vld),
      .byte_eof    (rx_eof),
      .crc_ok      (rx_crc_ok),
      .da_ok       (rx_da_ok),
      .found_now   (found_now),
      .pat_wake_en (pat_wake_en),
      .pme_gate_en (pme_gate_en),
      .bus_pme_en  (bus_pme_en),
      .link_up_evt (link_up_evt),
      .status_w1c  (pme_status_w1c),
      .pme_status  (pme_status),
      .wake_n      (wake_n),
      .wake_req    (wake_req)
   );

   a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pme_status && wake_n && !wake_req));
endmodule

// File: tb/wkp_detect_bench.sv
module wkp_detect_bench;
   localparam logic [47:0] STN = 48'h02_11_FF_33_FF_55;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic rx_vld = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 1, rx_da_ok = 1;
   logic [7:0] rx_byte = 8'h00;
   logic pat_wake_en = 1, pme_gate_en = 1, bus_pme_en = 1;
   logic link_up_evt = 0, pme_status_w1c = 0;
   logic pme_status, wake_n, wake_req;

   wkp_detect u_wkp_detect (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_da_ok(rx_da_ok),
      .stn_addr(STN), .pat_wake_en(pat_wake_en), .pme_gate_en(pme_gate_en),
      .bus_pme_en(bus_pme_en), .link_up_evt(link_up_evt),
      .pme_status_w1c(pme_status_w1c), .pme_status(pme_status),
      .wake_n(wake_n), .wake_req(wake_req)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] frm [0:255];
   int flen = 0;

   function automatic logic [7:0] ab(int i);
      return STN[(5-i)*8 +: 8];
   endfunction

   task automatic check(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic put(logic [7:0] b);
      frm[flen] = b;
      flen++;
   endtask

   task automatic put_pattern(int copies);
      for (int i = 0; i < 6; i++) put(8'hFF);
      for (int c = 0; c < copies; c++)
         for (int i = 0; i < 6; i++) put(ab(i));
   endtask

   task automatic send(bit eof_on, bit crc, bit da, int gap_every);
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         rx_vld = 1; rx_byte = frm[i]; rx_sof = (i == 0);
         rx_eof = eof_on && (i == flen - 1);
         rx_crc_ok = crc; rx_da_ok = da;
         if (gap_every > 0 && (i % gap_every) == gap_every - 1 && i != flen - 1) begin
            @(negedge clk);
            rx_vld = 0; rx_sof = 0; rx_eof = 0;
         end
      end
      @(negedge clk);
      rx_vld = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 1; rx_da_ok = 1;
      flen = 0;
   endtask

   task automatic clear_status();
      @(negedge clk); pme_status_w1c = 1;
      @(negedge clk); pme_status_w1c = 0;
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R10", "status after reset", pme_status, 1'b0);
      check("R10", "wake_n after reset", wake_n, 1'b1);
      check("R10", "wake_req after reset", wake_req, 1'b0);

      // R1 R2: offset sweep, varied trailers, gaps on odd offsets
      for (int off = 0; off <= 10; off++) begin
         clear_status();
         for (int k = 0; k < off; k++) put(8'h10 + 8'(k));
         put_pattern(16);
         for (int k = 0; k < off % 3; k++) put(8'hA5);
         send(1, 1, 1, (off % 2) ? 7 : 0);
         check("R2", $sformatf("status offset %0d", off), pme_status, 1'b1);
         check("R7", "wake_n low", wake_n, 1'b0);
         check("R7", "wake_req pulse", wake_req, 1'b1);
         @(negedge clk);
         check("R7", "wake_req one cycle", wake_req, 1'b0);
      end
      clear_status();
      check("R8", "status cleared", pme_status, 1'b0);
      check("R8", "wake_n released", wake_n, 1'b1);

      // R3: long 0xFF runs
      for (int extra = 1; extra <= 5; extra++) begin
         clear_status();
         put(8'h44);
         for (int k = 0; k < extra; k++) put(8'hFF);
         put_pattern(16); put(8'h00);
         send(1, 1, 1, 0);
         check("R3", $sformatf("long run +%0d", extra), pme_status, 1'b1);
      end

      // R3: failing byte is 0xFF and starts a new sync run (needs 4 more)
      for (int more = 3; more <= 4; more++) begin
         clear_status();
         for (int k = 0; k < 6; k++) put(8'hFF);
         put(ab(0)); put(ab(1)); put(ab(2)); put(8'hFF);
         for (int k = 0; k < more; k++) put(8'hFF);
         for (int c = 0; c < 16; c++) for (int i = 0; i < 6; i++) put(ab(i));
         put(8'h00);
         send(1, 1, 1, 0);
         check("R3", $sformatf("ff restart more=%0d", more), pme_status, logic'(more == 4));
      end

      // R3: partial match broken by other byte, then full pattern
      clear_status();
      put_pattern(6); put(ab(0)); put(ab(1)); put(8'h00);
      put_pattern(16);
      send(1, 1, 1, 0);
      check("R3", "restart after partial", pme_status, 1'b1);

      // R9: corrupt each pattern byte
      for (int p = 0; p < 102; p++) begin
         clear_status();
         put(8'h20); put(8'h21); put_pattern(16); put(8'h22);
         frm[2+p] = frm[2+p] ^ 8'h01;
         send(1, 1, 1, 0);
         check("R9", $sformatf("corrupt byte %0d", p), pme_status, 1'b0);
      end

      // R9: 15 copies only
      clear_status();
      put_pattern(15); put(8'h01);
      send(1, 1, 1, 0);
      check("R9", "fifteen copies", pme_status, 1'b0);

      // R9: pattern in a frame without end, next frame plain
      clear_status();
      put_pattern(16);
      send(0, 1, 1, 0);
      check("R9", "no end no status", pme_status, 1'b0);
      for (int k = 0; k < 10; k++) put(8'h30 + 8'(k));
      send(1, 1, 1, 0);
      check("R9", "sof drops match", pme_status, 1'b0);

      // R4: qualifiers
      for (int q = 0; q < 3; q++) begin
         clear_status();
         put_pattern(16);
         send(1, q != 0, q != 1, 0);
         check("R4", $sformatf("qualifier case %0d", q), pme_status, logic'(q == 2));
      end

      // R5: enable combinations
      for (int e = 0; e < 4; e++) begin
         clear_status();
         pat_wake_en = e[0]; pme_gate_en = e[1];
         put_pattern(16);
         send(1, 1, 1, 0);
         check("R5", $sformatf("enables %0d", e), pme_status, logic'(e == 3));
      end
      pat_wake_en = 1; pme_gate_en = 1;

      // R7: bus enable off
      clear_status();
      bus_pme_en = 0;
      put_pattern(16);
      send(1, 1, 1, 0);
      check("R7", "status with bus off", pme_status, 1'b1);
      check("R7", "wake_n high bus off", wake_n, 1'b1);
      check("R7", "no req bus off", wake_req, 1'b0);
      @(negedge clk); bus_pme_en = 1; #1;
      check("R7", "wake_n low after bus on", wake_n, 1'b0);

      // R6: link-up
      for (int g = 0; g < 2; g++) begin
         clear_status();
         pme_gate_en = logic'(g);
         @(negedge clk); link_up_evt = 1;
         @(negedge clk); link_up_evt = 0;
         check("R6", $sformatf("link up gate %0d", g), pme_status, logic'(g));
      end
      pme_gate_en = 1;

      // R8: clear and event in the same cycle
      clear_status();
      @(negedge clk); link_up_evt = 1; pme_status_w1c = 1;
      @(negedge clk); link_up_evt = 0; pme_status_w1c = 0;
      check("R8", "event wins over clear", pme_status, 1'b1);
      clear_status();
      check("R8", "clear alone", pme_status, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule